// File: doc/BRIEF.md
# UART Receive Queue with Status Flags

This block holds received characters for one UART channel between the deserializer and the CPU. Each completed character arrives with a one-cycle strobe, together with its break, parity-error and framing-error flags. It is stored in a first-in first-out queue of 8 entries, or 16 when the deep setting is chosen. When the queue is full, one more character can wait in a holding stage that stands in for the shift register. A read frees a slot, and the waiting character moves into the queue in the same cycle.

The block keeps three status outputs. `rx_ready` says that a character is waiting. `fifo_full` says that every queue slot is taken. `overrun` is a sticky flag that says a character was lost. The CPU side pops the head entry with `rd_pop`. The head's data and flags are always shown on the read outputs. A clear command resets the error flag, and a synchronous receiver reset empties everything.

Top module: `uart_rx_fifo_status`

## Requirements
- R1: After `rst_n` low, or `rx_reset` high, at a clock edge, `rx_ready`, `fifo_full` and `overrun` are 0, and the queue and the holding stage are empty.
- R2: Characters leave in arrival order. While `rx_ready` is 1, `rd_data`, `rd_brk`, `rd_par` and `rd_frm` show the oldest stored character and its flags.
- R3: The queue holds 8 entries when `DEEP_MODE` is 0 and 16 entries when it is 1. `fifo_full` rises only when that number is reached.
- R4: `rx_ready` rises in the cycle after a character enters the queue. It falls only after the pop that leaves the queue empty.
- R5: `fifo_full` rises in the cycle after the entry that fills the last slot. It falls after a pop when no character is waiting in the holding stage.
- R6: A character that arrives while the queue is full and the holding stage is empty is kept in the holding stage, and `overrun` stays 0. The next pop moves it into the queue, and `fifo_full` stays 1.
- R7: A character that arrives while the queue is full and the holding stage is occupied sets `overrun`. The held character and its flags are dropped, and the new character and its flags take its place.
- R8: `overrun` stays set until `clr_err` is high at an edge. If a new overrun happens in that same cycle, `overrun` remains 1.
- R9: If `rd_pop` and a new arrival occur in the same cycle while the queue is full and a character is held, the pop is applied first. No overrun occurs, and both characters are kept in order.
- R10: `rd_pop` while the queue is empty has no effect. The status stays clear, and a later character is still read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_reset | input | 1 | Synchronous receiver reset, active high |
| char_valid | input | 1 | One-cycle strobe: a character has completed |
| char_data | input | 8 | Received character |
| char_brk | input | 1 | Break seen on this character |
| char_par | input | 1 | Parity error on this character |
| char_frm | input | 1 | Framing error on this character |
| rd_pop | input | 1 | CPU read: remove the head entry |
| clr_err | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head entry data |
| rd_brk | output | 1 | Head entry break flag |
| rd_par | output | 1 | Head entry parity-error flag |
| rd_frm | output | 1 | Head entry framing-error flag |
| rx_ready | output | 1 | At least one character is stored |
| fifo_full | output | 1 | Every queue slot is occupied |
| overrun | output | 1 | Sticky: a character was lost |

## Verification
The bench builds two copies side by side from the same stimulus. One uses `DEEP_MODE` 0 (8 entries) and the other uses `DEEP_MODE` 1 (16 entries). The shallow copy makes it cheap to reach the fill, hold and overrun corners, including a pop and an arrival in the same cycle. The deep copy shows that the full threshold and the overrun point move with the parameter. Because both copies receive the same inputs, the shallow copy overruns while the deep copy is still filling, and the bench checks that the deep copy stays clean in that window.

// File: rtl/rxq_pkg.sv
// Shared types for the receive queue.
// Assumes: characters are 8 bits wide and carry three error flags.
package rxq_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              brk;
        logic              par;
        logic              frm;
    } rx_char_t;
endpackage

// File: rtl/rxq_store.sv
// Circular buffer that holds received characters and keeps an occupancy count.
// Assumes: DEPTH is a power of two. The caller never pushes into a full buffer
// unless it pops in the same cycle, and never pops an empty one.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  rx_char_t                   wdata,
    input  logic                       pop,
    output rx_char_t                   head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;

    // Write the incoming character at the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance the pointers and the count on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push);
            rd_ptr <= rd_ptr + AW'(pop);
            count  <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count != CW'(DEPTH)));   // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));                       // R10
endmodule

// File: rtl/rxq_park.sv
// Holding stage in front of the queue. It routes each arrival either into the
// queue or into the holding slot, moves a held character in once a slot frees,
// and reports an overrun when a held character is overwritten.
// Assumes: pop is already qualified (never high while the queue is empty).
module rxq_park
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       arr_vld,
    input  rx_char_t                   arr_char,
    input  logic                       pop,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       push,
    output rx_char_t                   push_char,
    output logic                       ovr_evt,
    output logic                       park_vld
);
    localparam int CW = $clog2(DEPTH+1);

    rx_char_t park_q;
    logic     park_load;
    logic     room;

    // A slot is free once this cycle's pop has been applied.
    assign room = (count != CW'(DEPTH)) || pop;

    // Choose what enters the queue and what lands in the holding slot.
    always_comb begin
        push      = 1'b0;
        push_char = arr_char;
        ovr_evt   = 1'b0;
        park_load = 1'b0;
        if (park_vld) begin
            if (room) begin
                push      = 1'b1;
                push_char = park_q;
                park_load = arr_vld;
            end else begin
                park_load = arr_vld;
                ovr_evt   = arr_vld;
            end
        end else if (arr_vld) begin
            if (room) begin
                push = 1'b1;
            end else begin
                park_load = 1'b1;
            end
        end
    end

    // Track whether the holding slot is occupied.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            park_vld <= 1'b0;
        end else if (park_load) begin
            park_vld <= 1'b1;
        end else if (push && park_vld) begin
            park_vld <= 1'b0;
        end
    end

    // Capture the character that is held.
    always_ff @(posedge clk) begin
        if (park_load) begin
            park_q <= arr_char;
        end
    end

    AST_PARK_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        park_vld |-> (count == CW'(DEPTH)));          // R6
    AST_HELD_MOVES_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (park_vld && pop && !arr_vld && !clr) |=> !park_vld);   // R6
endmodule

// File: rtl/rxq_status.sv
// Status flags driven by queue events: ready, full and sticky overrun.
// Assumes: push and pop are the queue's actual write and read strobes, and
// count is the occupancy before this cycle's events.
module rxq_status #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       ovr_evt,
    input  logic                       clr_err,
    output logic                       rx_ready,
    output logic                       fifo_full,
    output logic                       overrun
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0] after_cnt;

    // Occupancy after this cycle's pop and push.
    assign after_cnt = count + CW'(push) - CW'(pop);

    // Ready: set on any entry, cleared by the pop that leaves the queue empty.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rx_ready <= 1'b0;
        end else if (push) begin
            rx_ready <= 1'b1;
        end else if (pop && count == CW'(1)) begin
            rx_ready <= 1'b0;
        end
    end

    // Full: set when an entry takes the last slot, cleared by a pop with no refill.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fifo_full <= 1'b0;
        end else if (push && after_cnt == CW'(DEPTH)) begin
            fifo_full <= 1'b1;
        end else if (pop && !push) begin
            fifo_full <= 1'b0;
        end
    end

    // Overrun: sticky until cleared; a new event beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            overrun <= 1'b0;
        end else if (ovr_evt) begin
            overrun <= 1'b1;
        end else if (clr_err) begin
            overrun <= 1'b0;
        end
    end

    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !clr) |=> overrun);                       // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_err && !clr) |=> overrun);           // R8
endmodule

// File: rtl/uart_rx_fifo_status.sv
// Receive queue for one UART channel with a holding stage and status flags.
// Assumes: char_valid is a single-cycle strobe per character, and all inputs
// are synchronous to clk.
module uart_rx_fifo_status
    import rxq_pkg::*;
#(
    parameter bit DEEP_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_reset,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              char_brk,
    input  logic              char_par,
    input  logic              char_frm,
    input  logic              rd_pop,
    input  logic              clr_err,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_brk,
    output logic              rd_par,
    output logic              rd_frm,
    output logic              rx_ready,
    output logic              fifo_full,
    output logic              overrun
);
    localparam int DEPTH = DEEP_MODE ? 16 : 8;
    localparam int CW    = $clog2(DEPTH+1);

    rx_char_t      arr_char;
    rx_char_t      push_char;
    rx_char_t      head;
    logic [CW-1:0] count;
    logic          pop_ok;
    logic          push;
    logic          ovr_evt;
    logic          park_vld;

    assign arr_char = '{data: char_data, brk: char_brk, par: char_par, frm: char_frm};
    assign pop_ok   = rd_pop && (count != '0);

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_reset),
        .push  (push),
        .wdata (push_char),
        .pop   (pop_ok),
        .head  (head),
        .count (count)
    );

    rxq_park #(.DEPTH(DEPTH)) u_park (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_reset),
        .arr_vld   (char_valid),
        .arr_char  (arr_char),
        .pop       (pop_ok),
        .count     (count),
        .push      (push),
        .push_char (push_char),
        .ovr_evt   (ovr_evt),
        .park_vld  (park_vld)
    );

    rxq_status #(.DEPTH(DEPTH)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_reset),
        .push      (push),
        .pop       (pop_ok),
        .count     (count),
        .ovr_evt   (ovr_evt),
        .clr_err   (clr_err),
        .rx_ready  (rx_ready),
        .fifo_full (fifo_full),
        .overrun   (overrun)
    );

    assign rd_data = head.data;
    assign rd_brk  = head.brk;
    assign rd_par  = head.par;
    assign rd_frm  = head.frm;

    AST_READY_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready == (count != '0));                       // R4
    AST_FULL_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full == (count == CW'(DEPTH)));              // R5
    AST_RESET_CLEARS: assert property (@(posedge clk)
        (!rst_n || rx_reset) |=> (!rx_ready && !fifo_full && !overrun && !park_vld));  // R1
endmodule

// File: tb/uart_rx_fifo_status_bench.sv
module uart_rx_fifo_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_reset = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = '0;
    logic       char_brk = 1'b0;
    logic       char_par = 1'b0;
    logic       char_frm = 1'b0;
    logic       rd_pop = 1'b0;
    logic       clr_err = 1'b0;

    logic [7:0] rd_data, d_rd_data;
    logic       rd_brk, rd_par, rd_frm, rx_ready, fifo_full, overrun;
    logic       d_rd_brk, d_rd_par, d_rd_frm, d_rx_ready, d_fifo_full, d_overrun;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    uart_rx_fifo_status #(.DEEP_MODE(1'b0)) u_uart_rx_fifo_status (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .char_valid(char_valid),
        .char_data(char_data), .char_brk(char_brk), .char_par(char_par), .char_frm(char_frm),
        .rd_pop(rd_pop), .clr_err(clr_err), .rd_data(rd_data), .rd_brk(rd_brk),
        .rd_par(rd_par), .rd_frm(rd_frm), .rx_ready(rx_ready), .fifo_full(fifo_full),
        .overrun(overrun));

    uart_rx_fifo_status #(.DEEP_MODE(1'b1)) u_uart_rx_fifo_status_deep (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .char_valid(char_valid),
        .char_data(char_data), .char_brk(char_brk), .char_par(char_par), .char_frm(char_frm),
        .rd_pop(rd_pop), .clr_err(clr_err), .rd_data(d_rd_data), .rd_brk(d_rd_brk),
        .rd_par(d_rd_par), .rd_frm(d_rd_frm), .rx_ready(d_rx_ready), .fifo_full(d_fifo_full),
        .overrun(d_overrun));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, applied after a falling edge and removed at the next one.
    task automatic drive(input logic v, input logic [7:0] d, input logic [2:0] f,
                         input logic p, input logic c, input logic r);
        char_valid = v;
        char_data  = d;
        {char_brk, char_par, char_frm} = f;
        rd_pop   = p;
        clr_err  = c;
        rx_reset = r;
        @(negedge clk);
        char_valid = 1'b0;
        rd_pop     = 1'b0;
        clr_err    = 1'b0;
        rx_reset   = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] f);
        drive(1'b1, d, f, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
    endtask

    // Check the head of the shallow copy, then pop it.
    task automatic pop_exp(input string tag, input logic [7:0] d, input logic [2:0] f);
        chk({tag, " data"}, rd_data, d);
        chk({tag, " flags"}, {rd_brk, rd_par, rd_frm}, f);
        drive(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic fill8();
        for (int i = 0; i < 8; i++) begin
            send(8'h10 + 8'(i), 3'(i));
        end
    endtask

    task automatic t_reset_state();
        chk("R1 ready after rst_n", rx_ready, 0);
        chk("R1 full after rst_n", fifo_full, 0);
        chk("R1 overrun after rst_n", overrun, 0);
    endtask

    task automatic t_order();
        do_reset();
        drive(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0);
        chk("R10 ready after empty pop", rx_ready, 0);
        chk("R10 full after empty pop", fifo_full, 0);
        send(8'hA1, 3'b100);
        chk("R4 ready after first entry", rx_ready, 1);
        send(8'hB2, 3'b010);
        send(8'hC3, 3'b001);
        pop_exp("R2 first", 8'hA1, 3'b100);
        chk("R4 ready holds", rx_ready, 1);
        pop_exp("R2 second", 8'hB2, 3'b010);
        chk("R4 ready holds with one left", rx_ready, 1);
        pop_exp("R2 third", 8'hC3, 3'b001);
        chk("R4 ready clears when empty", rx_ready, 0);
    endtask

    task automatic t_park();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            send(8'h10 + 8'(i), 3'(i));
            chk("R5 full threshold", fifo_full, (i == 7) ? 1 : 0);
        end
        send(8'h99, 3'b101);
        chk("R6 full with held char", fifo_full, 1);
        chk("R6 no overrun on hold", overrun, 0);
        pop_exp("R6 head", 8'h10, 3'b000);
        chk("R6 full stays after pop with held", fifo_full, 1);
        pop_exp("R5 next", 8'h11, 3'b001);
        chk("R5 full clears without held", fifo_full, 0);
        for (int i = 2; i < 8; i++) begin
            pop_exp("R6 drain", 8'h10 + 8'(i), 3'(i));
        end
        pop_exp("R6 held char last", 8'h99, 3'b101);
        chk("R4 empty after drain", rx_ready, 0);
    endtask

    task automatic t_overrun();
        do_reset();
        fill8();
        send(8'h91, 3'b001);
        chk("R7 no overrun yet", overrun, 0);
        send(8'hA2, 3'b110);
        chk("R7 overrun set", overrun, 1);
        for (int i = 0; i < 8; i++) begin
            pop_exp("R7 drain", 8'h10 + 8'(i), 3'(i));
        end
        pop_exp("R7 replacement", 8'hA2, 3'b110);
        chk("R7 empty after drain", rx_ready, 0);
        chk("R8 overrun sticky", overrun, 1);
        drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R8 cleared by command", overrun, 0);
        fill8();
        send(8'h91, 3'b001);
        drive(1'b1, 8'hA3, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R8 set wins over clear", overrun, 1);
        drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R8 clear afterwards", overrun, 0);
    endtask

    task automatic t_simul();
        do_reset();
        fill8();
        send(8'h91, 3'b011);
        chk("R9 head before", rd_data, 8'h10);
        drive(1'b1, 8'hB3, 3'b110, 1'b1, 1'b0, 1'b0);
        chk("R9 no overrun", overrun, 0);
        chk("R9 full kept", fifo_full, 1);
        for (int i = 1; i < 8; i++) begin
            pop_exp("R9 drain", 8'h10 + 8'(i), 3'(i));
        end
        pop_exp("R9 held", 8'h91, 3'b011);
        pop_exp("R9 arrival", 8'hB3, 3'b110);
        chk("R9 empty", rx_ready, 0);
    endtask

    task automatic t_rx_reset();
        fill8();
        send(8'h91, 3'b000);
        send(8'h92, 3'b000);
        do_reset();
        chk("R1 ready after rx_reset", rx_ready, 0);
        chk("R1 full after rx_reset", fifo_full, 0);
        chk("R1 overrun after rx_reset", overrun, 0);
        send(8'h5A, 3'b010);
        pop_exp("R1 fresh entry", 8'h5A, 3'b010);
        chk("R1 held slot emptied", rx_ready, 0);
    endtask

    task automatic t_deep();
        do_reset();
        for (int i = 0; i < 16; i++) begin
            send(8'h20 + 8'(i), 3'(i));
            if (i == 7) chk("R3 shallow full at 8", fifo_full, 1);
            if (i == 14) chk("R3 deep not full at 15", d_fifo_full, 0);
        end
        chk("R3 deep full at 16", d_fifo_full, 1);
        chk("R3 deep no overrun at 16", d_overrun, 0);
        chk("R3 shallow overrun by 16", overrun, 1);
        send(8'h77, 3'b000);
        chk("R3 deep holds 17th", d_overrun, 0);
        send(8'h78, 3'b000);
        chk("R3 deep overrun at 18", d_overrun, 1);
        chk("R3 deep head", d_rd_data, 8'h20);
        do_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_order();
        t_park();
        t_overrun();
        t_simul();
        t_rx_reset();
        t_deep();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule